// File: doc/BRIEF.md
# Sampling Converter Bus Control Logic

This block is the digital front end of a 12-bit successive-approximation sampling converter, seen from a microprocessor bus. It takes three control lines: an active-low chip select, a read/convert line, and a high-byte-enable. It qualifies a falling edge on read/convert as a request to sample and convert. It then raises a one-clock start pulse to the conversion engine and holds the busy flag low until the engine reports its result.

While a conversion is running, every control input is locked out. The captured result sits in an output latch. It is driven onto a 12-bit data bus with per-line output enables, which model three-state drivers. The enables open only when the bus is reading from an idle converter. In byte mode the four most significant bits are folded onto the low data lines, so an 8-bit host can fetch them.

All three control inputs are synchronized into the system clock through a parameterized chain of flops. A falling edge of read/convert counts only after the line has been seen low on two consecutive synchronized samples.

Top module: `conv_bus_ctrl`

## Requirements
- R1: A conversion starts only when synchronized read/convert goes from high to low and stays low for a second sampled clock, with chip select low, high-byte-enable low and the block idle. When read/convert is first driven low ahead of a rising edge, busy_n is still high after three rising edges and is low after the fourth. Any other combination of chip select and high-byte-enable leaves busy_n high.
- R2: start_conv is high for exactly one clock, in the same cycle busy_n first reads low.
- R3: busy_n stays low until conv_done is sampled high. On that edge, conv_code is captured into the output latch, busy_n is still low, and busy_n returns high on the next edge.
- R4: While busy_n is low, changes on chip select, read/convert and high-byte-enable have no effect. They give no second start pulse and do not extend or end the conversion, and a falling edge seen during busy does not start a conversion after busy ends.
- R5: All 12 bits of bus_oe are 1 only when synchronized read/convert is high, chip select is low and busy_n is high. Otherwise all 12 bits are 0, and chip select high forces them to 0.
- R6: With high-byte-enable low and the outputs enabled, bus_data equals the latched 12-bit code, bit for bit.
- R7: With high-byte-enable high and the outputs enabled, bus_data[3:0] carries code bits 11..8, bus_data[7:4] is 0, bus_data[11:8] keeps code bits 11..8, and all 12 enables are 1.
- R8: A conv_done pulse while no conversion is running is ignored. The latched code is held unchanged for as long as the block is idle.
- R9: Codes pass through as offset binary with no transformation: 0x000 is negative full scale, 0x7FF and 0x800 straddle mid-scale, and 0xFFF is positive full scale.
- R10: After reset, busy_n is 1, start_conv is 0, bus_oe is all 0 and the latched code is 0.
- R11: A low pulse on read/convert that lasts one clock or less, and so is seen low on only one synchronized sample, starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low (asynchronous to clk) |
| rd_conv | input | 1 | Read/convert line: falling edge requests conversion, high level permits reading (asynchronous) |
| hbe | input | 1 | High-byte-enable: 1 selects byte-mode arrangement and inhibits starts (asynchronous) |
| conv_done | input | 1 | End-of-conversion pulse from the conversion engine |
| conv_code | input | 12 | Offset-binary result from the conversion engine, valid with conv_done |
| busy_n | output | 1 | Low while a conversion is in progress |
| start_conv | output | 1 | One-clock request to the engine to sample and convert |
| bus_data | output | 12 | Data lines, 0 where not enabled |
| bus_oe | output | 12 | Per-line output enable modelling a three-state driver |

## Verification
On every clock, the embedded properties check four things. The start pulse is one cycle wide and lines up with busy falling. No start follows a busy cycle. The latch changes only in the cycle before busy rises, and it holds while idle. The outputs are closed during conversion, and byte mode zeroes the middle nibble. Only the bench scenarios can show the rest. These are the exact four-edge start latency, the rejection of every unqualified combination and of one-clock glitches, and the lockout against a full fake edge during busy. They also cover the data arrangement across every one of the 4096 codes in both output modes.

// File: rtl/conv_bus_pkg.sv
// Package: shared types and control-vector indices for the converter bus
// control block. Assumes a 3-bit synchronized control vector.
package conv_bus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2
    } conv_state_t;

    localparam int CTL_W   = 3;
    localparam int CTL_RD  = 0;
    localparam int CTL_CS  = 1;
    localparam int CTL_HBE = 2;

    // Reset image: read/convert low (no false edge), deselected, byte mode on
    localparam logic [CTL_W-1:0] CTL_RST = 3'b110;
endpackage

// File: rtl/conv_bus_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous control inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module conv_bus_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] pipe [STAGES];

    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop: capture the raw asynchronous level
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= RST_VAL;
                else        pipe[i] <= d_async;
            end
        end else begin : g_next
            // Later flops: settle the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= RST_VAL;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/conv_bus_start.sv
// Module: falling-edge qualifier for read/convert. A start fires when the
// synchronized line was high, then low for two samples, with chip select low,
// byte mode off and the sequencer idle. Assumes synchronized inputs.
module conv_bus_start (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic cs_n_s,
    input  logic hbe_s,
    input  logic idle,
    output logic fire
);
    logic rd_d1, rd_d2;

    // Two-deep history of the synchronized read/convert level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_d1 <= 1'b0;
            rd_d2 <= 1'b0;
        end else begin
            rd_d1 <= rd_s;
            rd_d2 <= rd_d1;
        end
    end

    // Qualified edge: high, low, low, with all enabling conditions met
    always_comb begin
        fire = rd_d2 & ~rd_d1 & ~rd_s & ~cs_n_s & ~hbe_s & idle;
    end
endmodule

// File: rtl/conv_bus_seq.sv
// Module: conversion sequencer. Issues the start pulse, holds busy until the
// engine reports, captures the result one clock before busy clears.
// Assumes conv_done is a synchronous pulse from the engine.
module conv_bus_seq
    import conv_bus_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_code,
    output logic              idle,
    output logic              start_conv,
    output logic [DATA_W-1:0] latch_q
);
    conv_state_t state;

    // State, start pulse and result latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            start_conv <= 1'b0;
            latch_q    <= '0;
        end else begin
            start_conv <= 1'b0;
            case (state)
                ST_IDLE: if (fire) begin
                    state      <= ST_CONV;
                    start_conv <= 1'b1;
                end
                ST_CONV: if (conv_done) begin
                    state   <= ST_DONE;
                    latch_q <= conv_code;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Idle flag; the top inverts nothing, busy_n is this flag
    always_comb idle = (state == ST_IDLE);

    // R2
    start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |=> !start_conv);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> start_conv);

    // R4
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> !start_conv);

    // R3
    latch_before_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_q) |=> idle);

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> $stable(latch_q));
endmodule

// File: rtl/conv_bus_out.sv
// Module: output enable decode and byte-mode arrangement. Models three-state
// lines as data plus per-line enable; disabled lines carry 0.
// Assumes NIB_W*2 <= DATA_W.
module conv_bus_out #(
    parameter int DATA_W = 12,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_s,
    input  logic              cs_n_s,
    input  logic              hbe_s,
    input  logic              busy_n,
    input  logic [DATA_W-1:0] latch_q,
    output logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] bus_oe
);
    localparam int BYTE_W = 2 * NIB_W;

    logic              en;
    logic [DATA_W-1:0] arranged;

    // Arrange the latched code for word or byte mode
    always_comb begin
        arranged = latch_q;
        if (hbe_s) begin
            arranged[NIB_W-1:0]      = latch_q[DATA_W-1 -: NIB_W];
            arranged[BYTE_W-1:NIB_W] = '0;
        end
    end

    // Enable only for a read of an idle, selected converter
    always_comb begin
        en       = rd_s & ~cs_n_s & busy_n;
        bus_oe   = {DATA_W{en}};
        bus_data = en ? arranged : '0;
    end

    // R5
    oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> (bus_oe == '0));

    // R7
    byte_mid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hbe_s && bus_oe[0]) |-> (bus_data[BYTE_W-1:NIB_W] == '0));
endmodule

// File: rtl/conv_bus_ctrl.sv
// Module: top of the converter bus control block. Synchronizes the control
// lines, qualifies starts, sequences conversions and drives the data lines.
// Assumes cs_n, rd_conv and hbe are asynchronous to clk.
module conv_bus_ctrl
    import conv_bus_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_conv,
    input  logic              hbe,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_code,
    output logic              busy_n,
    output logic              start_conv,
    output logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] bus_oe
);
    logic [CTL_W-1:0]  ctl_raw, ctl_s;
    logic              fire, idle;
    logic [DATA_W-1:0] latch_q;

    // Pack the raw control lines by index
    always_comb begin
        ctl_raw          = '0;
        ctl_raw[CTL_RD]  = rd_conv;
        ctl_raw[CTL_CS]  = cs_n;
        ctl_raw[CTL_HBE] = hbe;
    end

    conv_bus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ctl_raw), .q_sync(ctl_s)
    );

    conv_bus_start u_start (
        .clk(clk), .rst_n(rst_n),
        .rd_s(ctl_s[CTL_RD]), .cs_n_s(ctl_s[CTL_CS]), .hbe_s(ctl_s[CTL_HBE]),
        .idle(idle), .fire(fire)
    );

    conv_bus_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .conv_done(conv_done),
        .conv_code(conv_code), .idle(idle), .start_conv(start_conv),
        .latch_q(latch_q)
    );

    // Busy is the idle flag seen from the bus
    always_comb busy_n = idle;

    conv_bus_out #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .rd_s(ctl_s[CTL_RD]), .cs_n_s(ctl_s[CTL_CS]), .hbe_s(ctl_s[CTL_HBE]),
        .busy_n(busy_n), .latch_q(latch_q),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );
endmodule

// File: tb/conv_bus_ctrl_bench.sv
// Bench: exhaustive code sweep in both output modes plus directed start,
// lockout and glitch scenarios. Inputs change on falling clock edges.
module conv_bus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_conv = 1'b1;
    logic        hbe = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_code = '0;
    logic        busy_n, start_conv;
    logic [11:0] bus_data, bus_oe;

    int tests = 0;
    int fails = 0;
    int starts = 0;

    always #2 clk = ~clk;

    conv_bus_ctrl u_conv_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv), .hbe(hbe),
        .conv_done(conv_done), .conv_code(conv_code), .busy_n(busy_n),
        .start_conv(start_conv), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    // Count start pulses away from the active edge
    always @(negedge clk) if (rst_n && start_conv) starts++;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Qualified start; timing checks optional
    task automatic do_start(input bit timed);
        int s0 = starts;
        rd_conv = 1'b0;
        tick(3);
        if (timed) check(busy_n == 1'b1, "R1 busy early", busy_n, 1);
        tick(1);
        check(busy_n == 1'b0, "R1 busy low", busy_n, 0);
        if (timed) check(start_conv == 1'b1, "R2 start", start_conv, 1);
        rd_conv = 1'b1;
        tick(1);
        if (timed) begin
            check(start_conv == 1'b0, "R2 width", start_conv, 0);
            check(starts == s0 + 1, "R2 count", starts, s0 + 1);
        end
    endtask

    // Engine reports a code; optionally expect the read to open at once
    task automatic do_finish(input logic [11:0] code, input bit expect_en,
                             input bit timed);
        conv_done = 1'b1;
        conv_code = code;
        tick(1);
        conv_done = 1'b0;
        conv_code = ~code;
        if (timed) check(busy_n == 1'b0, "R3 busy after done", busy_n, 0);
        tick(1);
        check(busy_n == 1'b1, "R3 busy rise", busy_n, 1);
        if (expect_en) begin
            check(bus_oe == 12'hFFF, "R5 oe", bus_oe, 12'hFFF);
            check(bus_data == code, "R6 word", bus_data, code);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check(busy_n == 1'b1, "R10 busy", busy_n, 1);
        check(start_conv == 1'b0, "R10 start", start_conv, 0);
        check(bus_oe == 12'h000, "R10 oe", bus_oe, 0);
        cs_n = 1'b0;
        tick(2);
        check(bus_data == 12'h000, "R10 latch", bus_data, 0);
        tick(4);

        // R1 unqualified combinations of chip select and byte mode
        for (int k = 1; k < 4; k++) begin
            cs_n = k[0];
            hbe  = k[1];
            tick(4);
            rd_conv = 1'b0;
            tick(8);
            check(busy_n == 1'b1, "R1 unqualified", k, 1);
            rd_conv = 1'b1;
            tick(4);
        end
        cs_n = 1'b0;
        hbe  = 1'b0;
        tick(4);

        // R11 one-clock glitch on read/convert
        rd_conv = 1'b0;
        tick(1);
        rd_conv = 1'b1;
        tick(8);
        check(busy_n == 1'b1, "R11 glitch", busy_n, 1);
        check(starts == 0, "R11 starts", starts, 0);

        // R9 boundary codes
        begin
            logic [11:0] bnd [4] = '{12'h000, 12'h7FF, 12'h800, 12'hFFF};
            for (int b = 0; b < 4; b++) begin
                do_start(1'b1);
                do_finish(bnd[b], 1'b1, 1'b1);
                check(bus_data == bnd[b], "R9 code", bus_data, bnd[b]);
            end
        end

        // R4 lockout: toggle all controls and make a full fake edge while busy
        begin
            int s0;
            do_start(1'b1);
            s0 = starts;
            cs_n = 1'b1; hbe = 1'b1; tick(3);
            cs_n = 1'b0; hbe = 1'b0; tick(3);
            rd_conv = 1'b0; tick(6);
            check(busy_n == 1'b0, "R4 still busy", busy_n, 0);
            check(starts == s0, "R4 no restart", starts, s0);
            do_finish(12'hA5C, 1'b0, 1'b1);
            check(bus_oe == 12'h000, "R5 rd low", bus_oe, 0);
            tick(6);
            check(busy_n == 1'b1, "R4 no late start", busy_n, 1);
            rd_conv = 1'b1;
            tick(2);
            check(bus_oe == 12'hFFF, "R5 read mode", bus_oe, 12'hFFF);
            check(bus_data == 12'hA5C, "R6 read mode", bus_data, 12'hA5C);
        end

        // R5 chip select forces high impedance
        cs_n = 1'b1;
        tick(2);
        check(bus_oe == 12'h000, "R5 cs high", bus_oe, 0);
        cs_n = 1'b0;
        tick(2);

        // R8 stray done pulse while idle
        conv_done = 1'b1;
        conv_code = 12'h3C3;
        tick(1);
        conv_done = 1'b0;
        tick(2);
        check(bus_data == 12'hA5C, "R8 stray done", bus_data, 12'hA5C);
        check(busy_n == 1'b1, "R8 busy", busy_n, 1);
        tick(2);

        // R6 R7 exhaustive sweep of every code in both modes
        for (int c = 0; c < 4096; c++) begin
            logic [11:0] code = c[11:0];
            logic [11:0] exp_b = {code[11:8], 4'h0, code[11:8]};
            do_start(1'b0);
            do_finish(code, 1'b1, 1'b0);
            hbe = 1'b1;
            tick(2);
            check(bus_oe == 12'hFFF, "R7 oe", bus_oe, 12'hFFF);
            check(bus_data == exp_b, "R7 byte", bus_data, exp_b);
            hbe = 1'b0;
            tick(2);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule